// File: doc/BRIEF.md
# Machine Cycle Bus Sequencer

This block runs one bus machine cycle of a small 8-bit processor that has a 16-bit address bus. A requester presents a cycle kind, an address and a write byte. When the sequencer is free it takes the request and steps through the T-states of that kind. The kinds are a short or long opcode fetch, a memory read or write, an I/O read or write, and a bus idle period. During those T-states it drives the address-latch, read, write and memory-versus-I/O strobes. It captures the byte returned on a read and raises a one-cycle completion pulse.

Each T-state is one clock cycle. Every transfer cycle starts with an address phase and a strobe phase. An opcode fetch can add one or three internal T-states after its bus transfer; no bus transfer happens in them. A bus idle period makes no bus reference, and the requester sets its length. Memories, ports, decoding and wait states sit outside the block.

Top module: `bus_cycle_seq`

## Requirements
- R1: A request is taken on a clock edge where req_valid is high and busy is low. busy is high from the first T-state to the last T-state of the cycle. A request made while busy is high is ignored: the running cycle keeps its kind, address, write byte and length.
- R2: The cycle kind sets the length in T-states. Kind code 0 (short fetch) lasts 4, kind code 1 (long fetch) lasts 6, and codes 2 (memory read), 3 (memory write), 4 (I/O read) and 5 (I/O write) each last 3.
- R3: Codes 6 and 7 are bus idle. The period lasts req_idle_len T-states, and a value of 0 counts as 1. During it ale, rd_strb, wr_strb, wdata_oe and io_sel stay low and addr_out is 0.
- R4: In a transfer cycle (codes 0 to 5), ale is high in T-state 1 only. addr_out carries the taken address in every T-state of the cycle. addr_out is 0 whenever busy is low.
- R5: rd_strb is high in T-state 2 only, and only for codes 0, 1, 2 and 4. The byte on bus_rdata at the end of T-state 2 appears on rdata_out in the done cycle.
- R6: For codes 3 and 5, wr_strb and wdata_oe are high in T-states 2 and 3, and wdata_out carries the taken write byte in those T-states. At all other times wdata_out is 0.
- R7: io_sel is high in every T-state of codes 4 and 5. It is low in all other cycles and while busy is low.
- R8: int_act is high in T-states 4 to 6 of a fetch, and no strobe is active in those T-states. int_act is low at all other times.
- R9: done is high for exactly one clock, in the cycle after the last T-state, and busy is low in that cycle. A request presented in that cycle is taken, so cycles can run back to back.
- R10: While rst_n is low, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one T-state per cycle |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_kind | input | 3 | Cycle kind code |
| req_addr | input | 16 | Memory or port address |
| req_wdata | input | 8 | Byte to write |
| req_idle_len | input | 4 | Length of a bus idle period |
| bus_rdata | input | 8 | Byte returned by memory or port |
| busy | output | 1 | Cycle in progress |
| ale | output | 1 | Address-latch strobe |
| rd_strb | output | 1 | Read strobe |
| wr_strb | output | 1 | Write strobe |
| io_sel | output | 1 | High selects the I/O space |
| int_act | output | 1 | Internal T-state of a fetch |
| addr_out | output | 16 | Bus address |
| wdata_out | output | 8 | Write byte |
| wdata_oe | output | 1 | Write byte driven |
| rdata_out | output | 8 | Captured read byte |
| done | output | 1 | Cycle complete pulse |

## Verification
A wrong T-state count or a stale length register shows up as done and the busy drop arriving one or more clocks early or late. That error is visible in the first cycle of the affected kind. A decode error shows at once as a strobe in the wrong T-state or as io_sel wrong for the kind. A request latch that is overwritten while busy shows within one T-state as a change of addr_out or wdata_out partway through a cycle. A capture taken at the wrong edge shows as a wrong rdata_out at done, because the bench's bus model returns a byte that depends on the address.

// File: rtl/bcs_pkg.sv
// Shared cycle-kind encoding and classification helpers for the bus
// machine-cycle sequencer. Assumes a 3-bit kind code.
package bcs_pkg;

    typedef enum logic [2:0] {
        KIND_FETCH_S = 3'd0,
        KIND_FETCH_L = 3'd1,
        KIND_MEM_RD  = 3'd2,
        KIND_MEM_WR  = 3'd3,
        KIND_IO_RD   = 3'd4,
        KIND_IO_WR   = 3'd5,
        KIND_IDLE    = 3'd6,
        KIND_IDLE_X  = 3'd7
    } cyc_kind_e;

    function automatic logic kind_is_fetch(cyc_kind_e k);
        return (k == KIND_FETCH_S) || (k == KIND_FETCH_L);
    endfunction

    function automatic logic kind_is_read(cyc_kind_e k);
        return kind_is_fetch(k) || (k == KIND_MEM_RD) || (k == KIND_IO_RD);
    endfunction

    function automatic logic kind_is_write(cyc_kind_e k);
        return (k == KIND_MEM_WR) || (k == KIND_IO_WR);
    endfunction

    function automatic logic kind_is_io(cyc_kind_e k);
        return (k == KIND_IO_RD) || (k == KIND_IO_WR);
    endfunction

    function automatic logic kind_is_xfer(cyc_kind_e k);
        return (k != KIND_IDLE) && (k != KIND_IDLE_X);
    endfunction

endpackage

// File: rtl/bcs_tcount.sv
// T-state counter. Starts at T-state 1 on start, counts up to the
// length loaded with the request, then drops busy. Assumes start is
// only raised while busy is low and start_len is at least 1.
module bcs_tcount #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] start_len,
    output logic             busy,
    output logic [CNT_W-1:0] tstate,
    output logic             last
);

    logic [CNT_W-1:0] len_q;

    // Track the running T-state and the length of the current cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy   <= 1'b0;
            tstate <= '0;
            len_q  <= '0;
        end else if (start) begin
            busy   <= 1'b1;
            tstate <= CNT_W'(1);
            len_q  <= start_len;
        end else if (busy) begin
            if (last) begin
                busy   <= 1'b0;
                tstate <= '0;
            end else begin
                tstate <= tstate + CNT_W'(1);
            end
        end
    end

    // Flag the final T-state of the running cycle.
    always_comb begin
        last = busy && (tstate == len_q);
    end

endmodule

// File: rtl/bcs_strobe_dec.sv
// Combinational strobe decoder. Maps the latched cycle kind and the
// current T-state onto the bus strobes, address and write-data drive.
// Assumes tstate counts from 1 while busy is high.
module bcs_strobe_dec
    import bcs_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    parameter int CNT_W  = 4
) (
    input  logic              busy,
    input  cyc_kind_e         kind,
    input  logic [CNT_W-1:0]  tstate,
    input  logic [ADDR_W-1:0] addr_q,
    input  logic [DATA_W-1:0] wdata_q,
    output logic              ale,
    output logic              rd_strb,
    output logic              wr_strb,
    output logic              io_sel,
    output logic              int_act,
    output logic [ADDR_W-1:0] addr_out,
    output logic [DATA_W-1:0] wdata_out,
    output logic              wdata_oe,
    output logic              cap_en
);

    logic xfer;
    logic in_t1;
    logic in_t2;
    logic in_t3;
    logic past_t3;

    // Decode T-state position within a busy transfer cycle.
    always_comb begin
        xfer    = busy && kind_is_xfer(kind);
        in_t1   = xfer && (tstate == CNT_W'(1));
        in_t2   = xfer && (tstate == CNT_W'(2));
        in_t3   = xfer && (tstate == CNT_W'(3));
        past_t3 = xfer && (tstate > CNT_W'(3));
    end

    // Drive strobes, address and write data from kind and T-state.
    always_comb begin
        ale       = in_t1;
        rd_strb   = in_t2 && kind_is_read(kind);
        cap_en    = rd_strb;
        wr_strb   = (in_t2 || in_t3) && kind_is_write(kind);
        wdata_oe  = wr_strb;
        wdata_out = wr_strb ? wdata_q : '0;
        io_sel    = xfer && kind_is_io(kind);
        int_act   = past_t3 && kind_is_fetch(kind);
        addr_out  = xfer ? addr_q : '0;
    end

endmodule

// File: rtl/bcs_capture.sv
// Read capture and completion stage. Samples the bus byte at the edge
// closing the read strobe T-state, and pulses done after the last
// T-state. Assumes cap_en is high for one T-state per read cycle.
module bcs_capture #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_en,
    input  logic              last,
    input  logic [DATA_W-1:0] bus_rdata,
    output logic [DATA_W-1:0] rdata_out,
    output logic              done
);

    // Hold the most recently captured read byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_out <= '0;
        end else if (cap_en) begin
            rdata_out <= bus_rdata;
        end
    end

    // Register the completion pulse one clock after the last T-state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done <= 1'b0;
        end else begin
            done <= last;
        end
    end

endmodule

// File: rtl/bus_cycle_seq.sv
// Bus machine-cycle sequencer top. Accepts one cycle request while idle,
// latches it, computes the cycle length from its kind, and runs the
// T-state counter, strobe decoder and read capture. Assumes the
// requester holds no expectation of acceptance while busy is high.
module bus_cycle_seq
    import bcs_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int DATA_W     = 8,
    parameter int IDLE_LEN_W = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    input  logic [2:0]            req_kind,
    input  logic [ADDR_W-1:0]     req_addr,
    input  logic [DATA_W-1:0]     req_wdata,
    input  logic [IDLE_LEN_W-1:0] req_idle_len,
    input  logic [DATA_W-1:0]     bus_rdata,
    output logic                  busy,
    output logic                  ale,
    output logic                  rd_strb,
    output logic                  wr_strb,
    output logic                  io_sel,
    output logic                  int_act,
    output logic [ADDR_W-1:0]     addr_out,
    output logic [DATA_W-1:0]     wdata_out,
    output logic                  wdata_oe,
    output logic [DATA_W-1:0]     rdata_out,
    output logic                  done
);

    localparam int CNT_W = (IDLE_LEN_W > 3) ? IDLE_LEN_W : 3;

    cyc_kind_e         kind_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic              start;
    logic [CNT_W-1:0]  start_len;
    logic [CNT_W-1:0]  tstate;
    logic              last;
    logic              cap_en;
    cyc_kind_e         req_kind_e;

    // Accept a request only while no cycle runs, and size it by kind.
    always_comb begin
        req_kind_e = cyc_kind_e'(req_kind);
        start      = req_valid && !busy;
        case (req_kind_e)
            KIND_FETCH_S: start_len = CNT_W'(4);
            KIND_FETCH_L: start_len = CNT_W'(6);
            KIND_IDLE,
            KIND_IDLE_X:  start_len = (req_idle_len == '0) ? CNT_W'(1)
                                                           : CNT_W'(req_idle_len);
            default:      start_len = CNT_W'(3);
        endcase
    end

    // Latch the request fields for the whole cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kind_q  <= KIND_IDLE;
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (start) begin
            kind_q  <= req_kind_e;
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
        end
    end

    bcs_tcount #(
        .CNT_W (CNT_W)
    ) tcount_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .start_len (start_len),
        .busy      (busy),
        .tstate    (tstate),
        .last      (last)
    );

    bcs_strobe_dec #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .CNT_W  (CNT_W)
    ) strobe_i (
        .busy      (busy),
        .kind      (kind_q),
        .tstate    (tstate),
        .addr_q    (addr_q),
        .wdata_q   (wdata_q),
        .ale       (ale),
        .rd_strb   (rd_strb),
        .wr_strb   (wr_strb),
        .io_sel    (io_sel),
        .int_act   (int_act),
        .addr_out  (addr_out),
        .wdata_out (wdata_out),
        .wdata_oe  (wdata_oe),
        .cap_en    (cap_en)
    );

    bcs_capture #(
        .DATA_W (DATA_W)
    ) capture_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .cap_en    (cap_en),
        .last      (last),
        .bus_rdata (bus_rdata),
        .rdata_out (rdata_out),
        .done      (done)
    );

endmodule

// File: rtl/bcs_checker.sv
// Protocol checker for the bus machine-cycle sequencer, bound to the
// top. Assumes the synchronous active-low reset of the top.
module bcs_checker #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              done,
    input logic              ale,
    input logic              rd_strb,
    input logic              wr_strb,
    input logic              io_sel,
    input logic              int_act,
    input logic              wdata_oe,
    input logic [ADDR_W-1:0] addr_out
);

    AST_ALE_FIRST_TSTATE: assert property (@(posedge clk) disable iff (!rst_n)
        ale |-> (busy && !$past(busy))); // R4

    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(addr_out)); // R4

    AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_strb && wr_strb)); // R6

    AST_RD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_strb |=> !rd_strb); // R5

    AST_WR_DRIVES_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        wr_strb |-> wdata_oe); // R6

    AST_IOSEL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(io_sel)); // R7

    AST_INT_QUIET_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        int_act |-> !(ale || rd_strb || wr_strb)); // R8

    AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy))); // R9

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R9

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !(ale || rd_strb || wr_strb || io_sel || int_act)); // R1

endmodule

bind bus_cycle_seq bcs_checker #(
    .ADDR_W (ADDR_W)
) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy     (busy),
    .done     (done),
    .ale      (ale),
    .rd_strb  (rd_strb),
    .wr_strb  (wr_strb),
    .io_sel   (io_sel),
    .int_act  (int_act),
    .wdata_oe (wdata_oe),
    .addr_out (addr_out)
);

// File: tb/bus_cycle_seq_tb_top.sv
`timescale 1ns/1ps
// Sweep bench for the bus machine-cycle sequencer: every kind, many
// addresses and write bytes, every idle length, requests during busy.
module bus_cycle_seq_tb_top;

    localparam int AW  = 16;
    localparam int DW  = 8;
    localparam int ILW = 4;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           req_valid = 1'b0;
    logic [2:0]     req_kind = '0;
    logic [AW-1:0]  req_addr = '0;
    logic [DW-1:0]  req_wdata = '0;
    logic [ILW-1:0] req_idle_len = '0;
    logic [DW-1:0]  bus_rdata;
    logic           busy, ale, rd_strb, wr_strb, io_sel, int_act, wdata_oe, done;
    logic [AW-1:0]  addr_out;
    logic [DW-1:0]  wdata_out, rdata_out;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    // Bus model: returned byte depends on address and space.
    assign bus_rdata = io_sel ? ~addr_out[7:0]
                              : (addr_out[7:0] ^ addr_out[15:8] ^ 8'h5A);

    bus_cycle_seq #(.ADDR_W(AW), .DATA_W(DW), .IDLE_LEN_W(ILW)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_idle_len(req_idle_len),
        .bus_rdata(bus_rdata), .busy(busy), .ale(ale), .rd_strb(rd_strb),
        .wr_strb(wr_strb), .io_sel(io_sel), .int_act(int_act),
        .addr_out(addr_out), .wdata_out(wdata_out), .wdata_oe(wdata_oe),
        .rdata_out(rdata_out), .done(done)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got=%0h exp=%0h t=%0t", tag, got, exp, $time);
        end
    endtask

    function automatic int exp_len(input int k, input int il);
        if (k == 0) return 4;
        if (k == 1) return 6;
        if (k >= 6) return (il == 0) ? 1 : il;
        return 3;
    endfunction

    function automatic logic [7:0] model_byte(input int k, input logic [15:0] a);
        if (k == 4) return ~a[7:0];
        return a[7:0] ^ a[15:8] ^ 8'h5A;
    endfunction

    // Check the quiet outputs while no cycle runs.
    task automatic chk_quiet(input string tag);
        chk({tag, " R1 busy"}, 32'(busy), 0);
        chk({tag, " R4 addr"}, 32'(addr_out), 0);
        chk({tag, " R7 io_sel"}, 32'(io_sel), 0);
        chk({tag, " R6 wdata"}, 32'(wdata_out), 0);
        chk({tag, " R8 int_act"}, 32'(int_act), 0);
    endtask

    // Run one cycle; called at a negedge, returns at the done negedge.
    task automatic run(input int k, input logic [15:0] a, input logic [7:0] wd,
                       input int il, input bit noise);
        int  len  = exp_len(k, il);
        bit  xf   = (k < 6);
        bit  rdk  = (k == 0) || (k == 1) || (k == 2) || (k == 4);
        bit  wrk  = (k == 3) || (k == 5);
        bit  iok  = (k == 4) || (k == 5);
        bit  fk   = (k < 2);
        req_valid    = 1'b1;
        req_kind     = 3'(k);
        req_addr     = a;
        req_wdata    = wd;
        req_idle_len = ILW'(il);
        for (int i = 1; i <= len + 1; i++) begin
            @(negedge clk);
            if (i <= len) begin
                chk("R1 busy in cycle", 32'(busy), 1);
                chk("R9 no early done", 32'(done), 0);
                chk("R4/R3 ale", 32'(ale), 32'(xf && i == 1));
                chk("R4/R3 addr", 32'(addr_out), xf ? 32'(a) : 0);
                chk("R5/R3 rd_strb", 32'(rd_strb), 32'(rdk && i == 2));
                chk("R6 wr_strb", 32'(wr_strb), 32'(wrk && (i == 2 || i == 3)));
                chk("R6 wdata_oe", 32'(wdata_oe), 32'(wrk && (i == 2 || i == 3)));
                chk("R6 wdata_out", 32'(wdata_out),
                    (wrk && (i == 2 || i == 3)) ? 32'(wd) : 0);
                chk("R7 io_sel", 32'(io_sel), 32'(iok));
                chk("R8 int_act", 32'(int_act), 32'(fk && i >= 4));
                if (noise) begin
                    req_valid = 1'b1;
                    req_kind  = 3'((k + 3) % 8);
                    req_addr  = ~a;
                    req_wdata = ~wd;
                    req_idle_len = ILW'(il + 5);
                end else begin
                    req_valid = 1'b0;
                end
            end else begin
                chk("R9 done pulse", 32'(done), 1);
                chk("R9 busy low at done", 32'(busy), 0);
                chk("R2 length ends", 32'(ale), 0);
                if (rdk)
                    chk("R5 read byte", 32'(rdata_out), 32'(model_byte(k, a)));
                req_valid = 1'b0;
            end
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R10 reset busy", 32'(busy), 0);
        chk("R10 reset done", 32'(done), 0);
        chk("R10 reset rdata", 32'(rdata_out), 0);
        chk("R10 reset strobes", 32'({ale, rd_strb, wr_strb, wdata_oe}), 0);
        chk_quiet("R10");
        req_valid = 1'b1;   // request under reset must not start a cycle
        @(negedge clk);
        chk("R10 held by reset", 32'(busy), 0);
        req_valid = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        chk_quiet("after reset");
        for (int k = 0; k < 8; k++) begin
            for (int j = 0; j < 16; j++) begin
                logic [15:0] a  = 16'h4105 + 16'(j * 16'h1357 + k * 16'h0211);
                logic [7:0]  wd = 8'(j * 37 + k * 11 + 3);
                run(k, a, wd, (k >= 6) ? j : (j ^ 4'hA), j[0]);
                if (j % 4 == 3) begin
                    @(negedge clk);
                    chk_quiet("gap");
                    chk("R9 single done", 32'(done), 0);
                end
            end
        end
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #400000;
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog R1 got=hung exp=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule